// File: doc/BRIEF.md
# Aliased Sub-Register File

This block is the general register storage of an integer datapath. It holds eight 32-bit general registers in which narrower operands alias onto the same storage: a register can be accessed as the whole word, as its low 16-bit half, or as either of the two bytes of that half. Next to it sits a bank of six 16-bit segment registers. Instruction decode and memory operands stay outside; the block sees register indices, an operand-size code and a byte-select bit on every access.

Two combinational read ports serve the operand fetch. A primary write port takes results and can widen them on the way in: a zero-extending or sign-extending move takes an 8-bit or 16-bit source value and fills the upper bits of the wider destination. A second write port carries an independent result. During an exchange it carries the other half of the swap. An exchange swaps the fields named by the two read ports in one clock edge. A segment register write is checked against its source kind. Any source other than a general register is refused and flagged.

Top module: `aliased_regfile`

## Requirements
- R1: A synchronous reset, active high, clears all general registers and all segment registers to zero.
- R2: Size code 2 (and the unused code 3) addresses the whole 32-bit register. Reads are combinational. A primary write with this size replaces all 32 bits at the rising clock edge.
- R3: Size code 1 addresses bits 15:0. A read returns them zero-extended to 32 bits. A write replaces them and keeps bits 31:16.
- R4: Size code 0 addresses one byte. The select bit low picks bits 7:0 and high picks bits 15:8. A read returns the byte in bits 7:0 with zeros above. A write replaces only that byte.
- R5: Extend code 1 on the primary port is a zero-extending move. The source is the low byte of the write data when the source-size bit is 0, and the low half when it is 1. The upper bits are zero, and the widened value is then written at the destination size.
- R6: Extend code 2 is a sign-extending move. It is the same as R5, but the upper bits are copies of the source's most significant bit. Extend code 0 writes the data unchanged.
- R7: With the exchange input high, the field named by read port 0 and the field named by read port 1 swap at one edge. Both fields use read port 0's size code. Each side receives the other's old value. The write-enable inputs of both write ports have no effect in that cycle.
- R8: The second write port writes on its own, using its own size and byte select. When both ports write the same register in one cycle, bits of both fields land, and the primary port's bits win where the fields overlap.
- R9: A segment write with source code 0 (general register) to index 0 to 5 stores the 16-bit data at the rising edge. The segment read port returns that register's content combinationally.
- R10: A segment write with source code 1, 2 or 3 raises the illegal-operation output in the same cycle. It leaves every segment register unchanged.
- R11: Segment indices 6 and 7 do not exist. Writes to them change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code (0 byte, 1 half, 2/3 word) |
| rd0_hi | input | 1 | Read port 0 byte select (1 = bits 15:8) |
| rd0_data | output | 32 | Read port 0 field, right-aligned, zero-filled |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 byte select |
| rd1_data | output | 32 | Read port 1 field, right-aligned, zero-filled |
| wr0_en | input | 1 | Primary write enable |
| wr0_idx | input | 3 | Primary write register index |
| wr0_size | input | 2 | Primary write destination size code |
| wr0_hi | input | 1 | Primary write byte select |
| wr0_ext | input | 2 | Extend mode (0 none, 1 zero, 2 sign, 3 none) |
| wr0_src_half | input | 1 | Extend source width (0 byte, 1 half) |
| wr0_data | input | 32 | Primary write data |
| wr1_en | input | 1 | Second write enable |
| wr1_idx | input | 3 | Second write register index |
| wr1_size | input | 2 | Second write size code |
| wr1_hi | input | 1 | Second write byte select |
| wr1_data | input | 32 | Second write data |
| xchg_en | input | 1 | Exchange the two read-port fields this cycle |
| seg_wr_en | input | 1 | Segment write enable |
| seg_wr_idx | input | 3 | Segment write index |
| seg_src | input | 2 | Source kind (0 general register, 1 immediate, 2 memory, 3 segment) |
| seg_wr_data | input | 16 | Segment write data |
| seg_illegal | output | 1 | Refused segment write this cycle |
| seg_rd_idx | input | 3 | Segment read index |
| seg_rd_data | output | 16 | Segment read data |

## Verification
Every register is loaded with a distinct word and then read back at every size and byte select on both ports, so a wrong slice, a missing zero fill or a swapped byte select shows up as a wrong field. Narrow writes into known words show that the bits outside the field survive. Extending moves are applied to source values at the sign boundary (00, 7F, 80, FF and the 16-bit counterparts), which separates zero fill from sign fill and byte sources from half sources. Exchanges between different registers, between the two bytes of one register, and with decoy writes enabled show that both sides move together and the decoys are ignored. Same-register writes on both ports show the merge order, and every segment source code and the two missing indices show the acceptance rule.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned HALFW   = 16;
    localparam int unsigned BYTEW   = 8;
    localparam int unsigned NGPR    = 8;
    localparam int unsigned GPR_IW  = $clog2(NGPR);
    localparam int unsigned SEGW    = 16;
    localparam int unsigned NSEG    = 6;
    localparam int unsigned SEG_IW  = $clog2(NSEG);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        EXT_NONE = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_SIGN = 2'd2,
        EXT_RSVD = 2'd3
    } extmode_e;

    typedef enum logic [1:0] {
        SRC_GPR = 2'd0,
        SRC_IMM = 2'd1,
        SRC_MEM = 2'd2,
        SRC_SEG = 2'd3
    } segsrc_e;

    typedef struct packed {
        logic              en;
        logic [GPR_IW-1:0] idx;
        opsize_e           size;
        logic              hi;
        logic [XLEN-1:0]   data;
    } wr_req_t;

    // Right-aligned, zero-filled view of one field of a register.
    function automatic logic [XLEN-1:0] field_get(input logic [XLEN-1:0] w,
                                                   input opsize_e sz,
                                                   input logic hi);
        logic [XLEN-1:0] r;
        case (sz)
            SZ_BYTE: r = hi ? {{(XLEN-BYTEW){1'b0}}, w[2*BYTEW-1:BYTEW]}
                            : {{(XLEN-BYTEW){1'b0}}, w[BYTEW-1:0]};
            SZ_HALF: r = {{(XLEN-HALFW){1'b0}}, w[HALFW-1:0]};
            default: r = w;
        endcase
        return r;
    endfunction

    // Insert a right-aligned value into one field, keeping the other bits.
    function automatic logic [XLEN-1:0] field_put(input logic [XLEN-1:0] old,
                                                   input logic [XLEN-1:0] d,
                                                   input opsize_e sz,
                                                   input logic hi);
        logic [XLEN-1:0] r;
        r = old;
        case (sz)
            SZ_BYTE: begin
                if (hi) r[2*BYTEW-1:BYTEW] = d[BYTEW-1:0];
                else    r[BYTEW-1:0]       = d[BYTEW-1:0];
            end
            SZ_HALF: r[HALFW-1:0] = d[HALFW-1:0];
            default: r = d;
        endcase
        return r;
    endfunction

    // Widen a byte or half source according to the move mode.
    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] d,
                                               input logic src_half,
                                               input extmode_e mode);
        logic [XLEN-1:0] r;
        case (mode)
            EXT_ZERO: r = src_half ? {{(XLEN-HALFW){1'b0}}, d[HALFW-1:0]}
                                   : {{(XLEN-BYTEW){1'b0}}, d[BYTEW-1:0]};
            EXT_SIGN: r = src_half ? {{(XLEN-HALFW){d[HALFW-1]}}, d[HALFW-1:0]}
                                   : {{(XLEN-BYTEW){d[BYTEW-1]}}, d[BYTEW-1:0]};
            default:  r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sr_extend.sv
module sr_extend
    import sr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] din,
    input  logic            src_half,
    input  extmode_e        mode,
    output logic [XLEN-1:0] dout
);

    always_comb dout = widen(din, src_half, mode);

    // R5: zero fill above a byte source
    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == EXT_ZERO && !src_half) |-> (dout[XLEN-1:BYTEW] == '0 && dout[BYTEW-1:0] == din[BYTEW-1:0]));

    // R6: sign fill above a byte source replicates bit 7
    assert_sign_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == EXT_SIGN && !src_half) |->
            ((dout[XLEN-1:BYTEW] == '0 || dout[XLEN-1:BYTEW] == '1) && dout[BYTEW] == din[BYTEW-1]));

    // R6: sign fill above a half source replicates bit 15
    assert_sign_half_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == EXT_SIGN && src_half) |->
            ((dout[XLEN-1:HALFW] == '0 || dout[XLEN-1:HALFW] == '1) && dout[HALFW] == din[HALFW-1]));

endmodule

// File: rtl/sr_gpr_array.sv
module sr_gpr_array
    import sr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wr_req_t                   w0,
    input  wr_req_t                   w1,
    output logic [NGPR-1:0][XLEN-1:0] regs
);

    for (genvar i = 0; i < NGPR; i++) begin : g_reg
        logic hit0, hit1;
        logic [XLEN-1:0] after1, after0;

        always_comb begin
            hit0   = w0.en && (w0.idx == GPR_IW'(i));
            hit1   = w1.en && (w1.idx == GPR_IW'(i));
            // second port first, primary on top so its bits win on overlap
            after1 = hit1 ? field_put(regs[i], w1.data, w1.size, w1.hi) : regs[i];
            after0 = hit0 ? field_put(after1, w0.data, w0.size, w0.hi) : after1;
        end

        always_ff @(posedge clk) begin
            if (rst) regs[i] <= '0;
            else     regs[i] <= after0;
        end

        // R2: a whole-word primary write replaces the register
        assert_word_write_R2: assert property (@(posedge clk) disable iff (rst)
            (w0.en && w0.idx == GPR_IW'(i) && (w0.size == SZ_WORD || w0.size == SZ_RSVD))
                |=> regs[i] == $past(w0.data));

        // R3: a half write keeps the upper half
        assert_half_keep_R3: assert property (@(posedge clk) disable iff (rst)
            (w0.en && w0.idx == GPR_IW'(i) && w0.size == SZ_HALF && !(w1.en && w1.idx == GPR_IW'(i)))
                |=> (regs[i][XLEN-1:HALFW] == $past(regs[i][XLEN-1:HALFW]) &&
                     regs[i][HALFW-1:0] == $past(w0.data[HALFW-1:0])));

        // R4: a byte write keeps the other byte of the low half and the upper half
        assert_byte_keep_R4: assert property (@(posedge clk) disable iff (rst)
            (w0.en && w0.idx == GPR_IW'(i) && w0.size == SZ_BYTE && !(w1.en && w1.idx == GPR_IW'(i)))
                |=> (regs[i][XLEN-1:HALFW] == $past(regs[i][XLEN-1:HALFW]) &&
                     ($past(w0.hi) ? regs[i][BYTEW-1:0] == $past(regs[i][BYTEW-1:0])
                                   : regs[i][2*BYTEW-1:BYTEW] == $past(regs[i][2*BYTEW-1:BYTEW]))));

        // R8: low-byte primary over a whole-word second write to the same register
        assert_primary_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (w0.en && w1.en && w0.idx == GPR_IW'(i) && w1.idx == GPR_IW'(i) &&
             w0.size == SZ_BYTE && !w0.hi && w1.size == SZ_WORD)
                |=> (regs[i][XLEN-1:BYTEW] == $past(w1.data[XLEN-1:BYTEW]) &&
                     regs[i][BYTEW-1:0] == $past(w0.data[BYTEW-1:0])));
    end

    // R1: reset clears every general register
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> regs == '0);

endmodule

// File: rtl/sr_seg_bank.sv
module sr_seg_bank
    import sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  segsrc_e           src,
    input  logic [SEGW-1:0]   wr_data,
    input  logic [2:0]        rd_idx,
    output logic [SEGW-1:0]   rd_data,
    output logic              illegal
);

    logic [NSEG-1:0][SEGW-1:0] segs;
    logic                      accept;

    always_comb begin
        illegal = wr_en && (src != SRC_GPR);
        accept  = wr_en && (src == SRC_GPR);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                segs[s] <= '0;
            else if (accept && wr_idx == 3'(s))
                segs[s] <= wr_data;
        end

        // R9: accepted write lands in the addressed segment register
        assert_seg_accept_R9: assert property (@(posedge clk) disable iff (rst)
            (wr_en && src == SRC_GPR && wr_idx == 3'(s)) |=> segs[s] == $past(wr_data));
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NSEG; s++)
            if (rd_idx == 3'(s)) rd_data = segs[s];
    end

    // R10: a refused write leaves the whole bank untouched
    assert_seg_reject_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && src != SRC_GPR) |=> segs == $past(segs));

    // R11: writes to missing indices leave the bank untouched
    assert_seg_range_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= 3'(NSEG)) |=> segs == $past(segs));

    // R1: reset clears the bank
    assert_seg_reset_R1: assert property (@(posedge clk) rst |=> segs == '0);

endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile
    import sr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  rd0_idx,
    input  logic [1:0]  rd0_size,
    input  logic        rd0_hi,
    output logic [31:0] rd0_data,
    input  logic [2:0]  rd1_idx,
    input  logic [1:0]  rd1_size,
    input  logic        rd1_hi,
    output logic [31:0] rd1_data,
    input  logic        wr0_en,
    input  logic [2:0]  wr0_idx,
    input  logic [1:0]  wr0_size,
    input  logic        wr0_hi,
    input  logic [1:0]  wr0_ext,
    input  logic        wr0_src_half,
    input  logic [31:0] wr0_data,
    input  logic        wr1_en,
    input  logic [2:0]  wr1_idx,
    input  logic [1:0]  wr1_size,
    input  logic        wr1_hi,
    input  logic [31:0] wr1_data,
    input  logic        xchg_en,
    input  logic        seg_wr_en,
    input  logic [2:0]  seg_wr_idx,
    input  logic [1:0]  seg_src,
    input  logic [15:0] seg_wr_data,
    output logic        seg_illegal,
    input  logic [2:0]  seg_rd_idx,
    output logic [15:0] seg_rd_data
);

    logic [NGPR-1:0][XLEN-1:0] regs;
    logic [XLEN-1:0]           moved;
    logic [XLEN-1:0]           xa, xb;
    wr_req_t                   req0, req1;

    sr_extend u_extend (
        .clk      (clk),
        .rst      (rst),
        .din      (wr0_data),
        .src_half (wr0_src_half),
        .mode     (extmode_e'(wr0_ext)),
        .dout     (moved)
    );

    // read ports
    always_comb begin
        rd0_data = field_get(regs[rd0_idx], opsize_e'(rd0_size), rd0_hi);
        rd1_data = field_get(regs[rd1_idx], opsize_e'(rd1_size), rd1_hi);
    end

    // exchange fields, both taken at read port 0's size
    always_comb begin
        xa = field_get(regs[rd0_idx], opsize_e'(rd0_size), rd0_hi);
        xb = field_get(regs[rd1_idx], opsize_e'(rd0_size), rd1_hi);
    end

    always_comb begin
        if (xchg_en) begin
            req0 = '{en: 1'b1, idx: rd0_idx, size: opsize_e'(rd0_size), hi: rd0_hi, data: xb};
            req1 = '{en: 1'b1, idx: rd1_idx, size: opsize_e'(rd0_size), hi: rd1_hi, data: xa};
        end else begin
            req0 = '{en: wr0_en, idx: wr0_idx, size: opsize_e'(wr0_size), hi: wr0_hi, data: moved};
            req1 = '{en: wr1_en, idx: wr1_idx, size: opsize_e'(wr1_size), hi: wr1_hi, data: wr1_data};
        end
    end

    sr_gpr_array u_gpr (
        .clk  (clk),
        .rst  (rst),
        .w0   (req0),
        .w1   (req1),
        .regs (regs)
    );

    sr_seg_bank u_seg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_wr_en),
        .wr_idx  (seg_wr_idx),
        .src     (segsrc_e'(seg_src)),
        .wr_data (seg_wr_data),
        .rd_idx  (seg_rd_idx),
        .rd_data (seg_rd_data),
        .illegal (seg_illegal)
    );

    // R7: a whole-word exchange of two registers swaps them at one edge
    assert_xchg_swap_R7: assert property (@(posedge clk) disable iff (rst)
        (xchg_en && rd0_size == 2'd2 && rd0_idx != rd1_idx)
            |=> (regs[$past(rd0_idx)] == $past(regs[rd1_idx]) &&
                 regs[$past(rd1_idx)] == $past(regs[rd0_idx])));

    // R7: registers outside an exchange are not written by the ignored enables
    assert_xchg_others_R7: assert property (@(posedge clk) disable iff (rst)
        (xchg_en && rd0_idx != 3'd7 && rd1_idx != 3'd7) |=> regs[7] == $past(regs[7]));

endmodule

// File: tb/aliased_regfile_test.sv
module aliased_regfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rd0_idx = '0, rd1_idx = '0;
    logic [1:0]  rd0_size = '0, rd1_size = '0;
    logic        rd0_hi = 1'b0, rd1_hi = 1'b0;
    logic [31:0] rd0_data, rd1_data;
    logic        wr0_en = 1'b0, wr0_hi = 1'b0, wr0_src_half = 1'b0;
    logic [2:0]  wr0_idx = '0;
    logic [1:0]  wr0_size = '0, wr0_ext = '0;
    logic [31:0] wr0_data = '0;
    logic        wr1_en = 1'b0, wr1_hi = 1'b0;
    logic [2:0]  wr1_idx = '0;
    logic [1:0]  wr1_size = '0;
    logic [31:0] wr1_data = '0;
    logic        xchg_en = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [2:0]  seg_wr_idx = '0, seg_rd_idx = '0;
    logic [1:0]  seg_src = '0;
    logic [15:0] seg_wr_data = '0, seg_rd_data;
    logic        seg_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m  [8];
    logic [15:0] sm [8];

    always #10 clk = ~clk;

    aliased_regfile uut (.*);

    function automatic logic [31:0] bget(logic [31:0] v, int sz, bit hi);
        if (sz == 0) return hi ? ((v >> 8) & 32'hFF) : (v & 32'hFF);
        if (sz == 1) return v & 32'hFFFF;
        return v;
    endfunction

    function automatic logic [31:0] bput(logic [31:0] old, logic [31:0] d, int sz, bit hi);
        logic [31:0] mask, sh;
        mask = (sz == 0) ? (hi ? 32'hFF00 : 32'h00FF) : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        sh   = (sz == 0 && hi) ? ((d & 32'hFF) << 8) : d;
        return (old & ~mask) | (sh & mask);
    endfunction

    function automatic logic [31:0] bext(logic [31:0] d, bit half, int mode);
        logic [31:0] v;
        if (mode != 1 && mode != 2) return d;
        v = half ? (d & 32'hFFFF) : (d & 32'hFF);
        if (mode == 2 && (half ? d[15] : d[7])) v = v - (half ? 32'd65536 : 32'd256);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rdchk(string req, int idx, int sz, bit hi);
        @(negedge clk);
        rd0_idx = 3'(idx); rd0_size = 2'(sz); rd0_hi = hi;
        rd1_idx = 3'(idx); rd1_size = 2'(sz); rd1_hi = hi;
        #2;
        chk({req, " port0"}, rd0_data, bget(m[idx], sz, hi));
        chk({req, " port1"}, rd1_data, bget(m[idx], sz, hi));
    endtask

    task automatic wr0(int idx, int sz, bit hi, logic [31:0] d, int ext, bit half);
        @(negedge clk);
        wr0_en = 1'b1; wr0_idx = 3'(idx); wr0_size = 2'(sz); wr0_hi = hi;
        wr0_data = d; wr0_ext = 2'(ext); wr0_src_half = half;
        @(negedge clk);
        wr0_en = 1'b0; wr0_ext = '0;
        m[idx] = bput(m[idx], bext(d, half, ext), sz, hi);
    endtask

    task automatic xchg(int i0, int i1, int sz, bit h0, bit h1);
        logic [31:0] a, b;
        @(negedge clk);
        rd0_idx = 3'(i0); rd0_size = 2'(sz); rd0_hi = h0;
        rd1_idx = 3'(i1); rd1_size = 2'(sz); rd1_hi = h1;
        xchg_en = 1'b1;
        // decoy writes to r7 that must be ignored
        wr0_en = 1'b1; wr0_idx = 3'd7; wr0_size = 2'd2; wr0_data = 32'hDEAD_BEEF;
        wr1_en = 1'b1; wr1_idx = 3'd7; wr1_size = 2'd2; wr1_data = 32'hFEED_F00D;
        a = bget(m[i0], sz, h0);
        b = bget(m[i1], sz, h1);
        @(negedge clk);
        xchg_en = 1'b0; wr0_en = 1'b0; wr1_en = 1'b0;
        m[i1] = bput(m[i1], a, sz, h1);
        m[i0] = bput(m[i0], b, sz, h0);
    endtask

    task automatic segwr(int idx, int src, logic [15:0] d);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_idx = 3'(idx); seg_src = 2'(src); seg_wr_data = d;
        #2;
        chk(src != 0 ? "R10 illegal flag" : "R9 flag low", 32'(seg_illegal), 32'(src != 0));
        @(negedge clk);
        seg_wr_en = 1'b0;
        if (src == 0 && idx < 6) sm[idx] = d;
    endtask

    task automatic segchk(string req, int idx);
        @(negedge clk);
        seg_rd_idx = 3'(idx);
        #2;
        chk(req, 32'(seg_rd_data), 32'(sm[idx]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m[i] = '0; sm[i] = '0; end
        // preload so reset has something to clear
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) wr0(i, 2, 0, 32'h1357_9BDF + 32'(i), 0, 0);
        for (int i = 0; i < 6; i++) segwr(i, 0, 16'hABC0 + 16'(i));
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) begin m[i] = '0; sm[i] = '0; end
        for (int i = 0; i < 8; i++) rdchk("R1 gpr reset", i, 2, 0);
        for (int i = 0; i < 8; i++) segchk("R1 seg reset", i);

        // R2 word writes, reads at every size
        for (int i = 0; i < 8; i++)
            wr0(i, 2, 0, 32'h8171_F00F ^ (32'(i) * 32'h0101_0101), 0, 0);
        for (int i = 0; i < 8; i++) begin
            rdchk("R2 word read", i, 2, 0);
            rdchk("R2 rsvd size as word", i, 3, 0);
            rdchk("R3 half read", i, 1, 0);
            rdchk("R4 low byte read", i, 0, 0);
            rdchk("R4 high byte read", i, 0, 1);
        end

        // R3 / R4 narrow writes keep other bits
        for (int i = 0; i < 8; i++) begin
            wr0(i, 1, 0, 32'hFFFF_0000 | 32'(16'h1234 + 16'(i)), 0, 0);
            rdchk("R3 half write", i, 2, 0);
            wr0(i, 0, 0, 32'hFFFF_FF00 | 32'(8'h40 + 8'(i)), 0, 0);
            rdchk("R4 low byte write", i, 2, 0);
            wr0(i, 0, 1, 32'hFFFF_FF00 | 32'(8'hC0 + 8'(i)), 0, 0);
            rdchk("R4 high byte write", i, 2, 0);
        end

        // R5 / R6 extending moves, byte and half sources, word and half destinations
        begin
            logic [31:0] srcv [6];
            srcv[0] = 32'hAAAA_AA00; srcv[1] = 32'h5555_557F;
            srcv[2] = 32'h1234_5680; srcv[3] = 32'h0000_00FF;
            srcv[4] = 32'hFFFF_7FFF; srcv[5] = 32'h0000_8000;
            for (int k = 0; k < 6; k++) begin
                for (int h = 0; h < 2; h++) begin
                    wr0(2, 2, 0, srcv[k], 1, h[0]);
                    rdchk("R5 zero extend to word", 2, 2, 0);
                    wr0(3, 2, 0, srcv[k], 2, h[0]);
                    rdchk("R6 sign extend to word", 3, 2, 0);
                    wr0(4, 2, 0, 32'hCAFE_CAFE, 0, 0);
                    wr0(4, 1, 0, srcv[k], 2, 1'b0);
                    rdchk("R6 sign extend byte to half", 4, 2, 0);
                    wr0(4, 1, 0, srcv[k], 1, 1'b0);
                    rdchk("R5 zero extend byte to half", 4, 2, 0);
                end
            end
            wr0(5, 2, 0, 32'h0000_0080, 0, 1);
            rdchk("R6 extend none passes data", 5, 2, 0);
        end

        // R7 exchanges
        wr0(7, 2, 0, 32'h7777_0707, 0, 0);
        xchg(1, 5, 2, 0, 0);
        rdchk("R7 word swap r1", 1, 2, 0);
        rdchk("R7 word swap r5", 5, 2, 0);
        rdchk("R7 decoy ignored r7", 7, 2, 0);
        wr0(2, 2, 0, 32'h1122_A1B2, 0, 0);
        xchg(2, 2, 0, 0, 1);
        rdchk("R7 byte swap same register", 2, 2, 0);
        xchg(3, 4, 1, 0, 0);
        rdchk("R7 half swap r3", 3, 2, 0);
        rdchk("R7 half swap r4", 4, 2, 0);
        xchg(0, 6, 0, 1, 0);
        rdchk("R7 byte swap r0", 0, 2, 0);
        rdchk("R7 byte swap r6", 6, 2, 0);
        rdchk("R7 decoy ignored again", 7, 2, 0);

        // R8 second port and collisions
        @(negedge clk);
        wr1_en = 1'b1; wr1_idx = 3'd6; wr1_size = 2'd0; wr1_hi = 1'b1; wr1_data = 32'h0000_00E6;
        @(negedge clk);
        wr1_en = 1'b0; m[6] = bput(m[6], 32'hE6, 0, 1);
        rdchk("R8 second port byte write", 6, 2, 0);
        @(negedge clk);
        wr1_en = 1'b1; wr1_idx = 3'd0; wr1_size = 2'd2; wr1_hi = 1'b0; wr1_data = 32'h1122_3344;
        wr0_en = 1'b1; wr0_idx = 3'd0; wr0_size = 2'd0; wr0_hi = 1'b0; wr0_data = 32'h0000_005A;
        @(negedge clk);
        wr1_en = 1'b0; wr0_en = 1'b0; m[0] = 32'h1122_335A;
        rdchk("R8 primary byte over second word", 0, 2, 0);
        @(negedge clk);
        wr1_en = 1'b1; wr1_idx = 3'd1; wr1_size = 2'd0; wr1_hi = 1'b1; wr1_data = 32'h0000_0099;
        wr0_en = 1'b1; wr0_idx = 3'd1; wr0_size = 2'd1; wr0_hi = 1'b0; wr0_data = 32'h0000_4321;
        @(negedge clk);
        wr1_en = 1'b0; wr0_en = 1'b0; m[1] = bput(m[1], 32'h4321, 1, 0);
        rdchk("R8 primary half over second byte", 1, 2, 0);
        @(negedge clk);
        wr1_en = 1'b1; wr1_idx = 3'd3; wr1_size = 2'd0; wr1_hi = 1'b1; wr1_data = 32'h0000_0033;
        wr0_en = 1'b1; wr0_idx = 3'd3; wr0_size = 2'd0; wr0_hi = 1'b0; wr0_data = 32'h0000_0044;
        @(negedge clk);
        wr1_en = 1'b0; wr0_en = 1'b0; m[3] = bput(bput(m[3], 32'h33, 0, 1), 32'h44, 0, 0);
        rdchk("R8 disjoint fields both land", 3, 2, 0);

        // R9 / R10 / R11 segment bank
        for (int i = 0; i < 6; i++) segwr(i, 0, 16'h5E00 + 16'(i * 17));
        for (int i = 0; i < 6; i++) segchk("R9 segment write", i);
        for (int s = 1; s < 4; s++) begin
            for (int i = 0; i < 6; i++) begin
                segwr(i, s, 16'hBAD0 + 16'(s));
                segchk("R10 refused write unchanged", i);
            end
        end
        segwr(6, 0, 16'h6666);
        segwr(7, 0, 16'h7777);
        for (int i = 0; i < 8; i++) segchk("R11 missing index", i);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule